// File: doc/BRIEF.md
# Bus Error and Halt Retry Controller

This block sits beside a bus-cycle sequencer and decides how a cycle flagged as faulty is handled. When the bus-error input is asserted during an active cycle, the block looks at the halt input. If halt is not asserted, the block ends the cycle and issues a one-cycle exception request. If halt was asserted earlier than the error, or in the same sample, the block ends the cycle and floats the address and data buses. It then stays parked until halt is released. At that point it issues a one-cycle rerun request, and the sequencer replays the failed cycle.

Both raw inputs pass through two-flop synchronizers. The address, write flag and byte strobes of the failed cycle are captured at the edge where the fault is taken. They are presented on the replay outputs for the rerun. A new cycle is allowed only after the synchronized bus error has been seen negated, so a held error is never taken twice.

Top module: `buserr_retry_ctrl`

## Requirements
- R1: After reset, exc_req_o, rerun_req_o, bus_float_o and strobe_term_o are low, start_ok_o is high and the replay outputs are zero.
- R2: A bus error or a halt seen while cyc_active_i is low raises neither exc_req_o nor bus_float_o nor strobe_term_o.
- R3: A bus error during an active cycle, with synchronized halt low in the same sample, raises exc_req_o for exactly one cycle. The pulse comes at the third rising edge after the raw error is driven. strobe_term_o rises at that same edge, and bus_float_o stays low.
- R4: Take a bus error during an active cycle where halt was driven at least as early as the error. bus_float_o and strobe_term_o rise at the third rising edge after the error, and exc_req_o stays low.
- R5: bus_float_o stays high until synchronized halt is low. At the third rising edge after halt is negated, rerun_req_o pulses for one cycle and bus_float_o falls.
- R6: Halt driven one or more cycles after the bus error does not count as earlier or together. The exception path of R3 is taken, and rerun_req_o never pulses for that fault.
- R7: replay_addr_o, replay_we_o and replay_strb_o take the cycle's address, write flag and 2-bit strobes at the fault edge. They hold those values while the cycle inputs change, until the next fault.
- R8: After a fault, strobe_term_o stays high and start_ok_o low until the bus error is negated. A held error during an active cycle raises no second exc_req_o. start_ok_o is never high while strobe_term_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_active_i | input | 1 | A bus cycle is in progress |
| cyc_addr_i | input | ADDR_W | Address of the current cycle |
| cyc_we_i | input | 1 | Current cycle is a write |
| cyc_strb_i | input | STRB_W | Byte strobes of the current cycle |
| bus_err_i | input | 1 | Raw bus error, active high |
| halt_i | input | 1 | Raw halt request, active high |
| exc_req_o | output | 1 | One-cycle bus-error exception request |
| rerun_req_o | output | 1 | One-cycle request to replay the failed cycle |
| bus_float_o | output | 1 | Tri-state enable for the address and data drivers |
| strobe_term_o | output | 1 | Forces the current cycle's strobes off |
| start_ok_o | output | 1 | A new cycle may be started |
| replay_addr_o | output | ADDR_W | Captured address of the failed cycle |
| replay_we_o | output | 1 | Captured write flag |
| replay_strb_o | output | STRB_W | Captured byte strobes |

## Verification
Every response is registered after a two-stage synchronizer. A change on a raw input therefore reaches the outputs at the third rising edge after it is driven, and a state that follows a rerun settles one edge later. The bench drives and samples 2 ns after each rising edge. It checks each pulse exactly at its due edge and again one edge later to confirm it has ended. A sweep moves the halt onset from two cycles before the error to two cycles after it, over several address and strobe patterns, so the boundary between halt-first and error-first is tested from both sides.

// File: rtl/buserr_retry_pkg.sv
package buserr_retry_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_FLOAT = 2'd1,
    ST_CLEAR = 2'd2
  } rc_state_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_TRAP = 2'd1,
    ACT_PARK = 2'd2
  } fault_act_e;

  // halt seen earlier or in the same sample as the error parks; otherwise trap
  function automatic fault_act_e fault_action(input logic fault, input logic halt_seen);
    if (!fault)    return ACT_NONE;
    if (halt_seen) return ACT_PARK;
    return ACT_TRAP;
  endfunction

endpackage

// File: rtl/buserr_sync.sv
module buserr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign sync_o = chain_q[LAST];
endmodule

// File: rtl/buserr_attr_hold.sv
module buserr_attr_hold #(
  parameter int ADDR_W = 24,
  parameter int STRB_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [STRB_W-1:0] strb_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [STRB_W-1:0] strb_o
);
  localparam int REC_W = ADDR_W + 1 + STRB_W;

  logic [REC_W-1:0] rec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rec_q <= '0;
    else if (capture_i) rec_q <= {addr_i, we_i, strb_i};
  end

  assign {addr_o, we_o, strb_o} = rec_q;
endmodule

// File: rtl/buserr_retry_fsm.sv
module buserr_retry_fsm
  import buserr_retry_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_active_i,
  input  logic berr_s_i,
  input  logic halt_s_i,
  output logic capture_o,
  output logic exc_req_o,
  output logic rerun_req_o,
  output logic bus_float_o,
  output logic strobe_term_o,
  output logic start_ok_o
);
  rc_state_e  state_q, state_d;
  fault_act_e act;
  logic       exc_d, rerun_d;
  logic       exc_q, rerun_q;

  assign act = fault_action((state_q == ST_RUN) && cyc_active_i && berr_s_i, halt_s_i);

  always_comb begin
    state_d   = state_q;
    exc_d     = 1'b0;
    rerun_d   = 1'b0;
    capture_o = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (act != ACT_NONE) capture_o = 1'b1;
        if (act == ACT_PARK) state_d = ST_FLOAT;
        if (act == ACT_TRAP) begin
          state_d = ST_CLEAR;
          exc_d   = 1'b1;
        end
      end
      ST_FLOAT: begin
        if (!halt_s_i) begin
          state_d = ST_CLEAR;
          rerun_d = 1'b1;
        end
      end
      ST_CLEAR: begin
        // wait for error negation so a held error is taken once
        if (!berr_s_i) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      exc_q   <= 1'b0;
      rerun_q <= 1'b0;
    end else begin
      state_q <= state_d;
      exc_q   <= exc_d;
      rerun_q <= rerun_d;
    end
  end

  assign exc_req_o     = exc_q;
  assign rerun_req_o   = rerun_q;
  assign bus_float_o   = (state_q == ST_FLOAT);
  assign strobe_term_o = (state_q != ST_RUN);
  assign start_ok_o    = (state_q == ST_RUN) && !berr_s_i;
endmodule

// File: rtl/buserr_retry_ctrl.sv
module buserr_retry_ctrl #(
  parameter int ADDR_W      = 24,
  parameter int STRB_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_active_i,
  input  logic [ADDR_W-1:0] cyc_addr_i,
  input  logic              cyc_we_i,
  input  logic [STRB_W-1:0] cyc_strb_i,
  input  logic              bus_err_i,
  input  logic              halt_i,
  output logic              exc_req_o,
  output logic              rerun_req_o,
  output logic              bus_float_o,
  output logic              strobe_term_o,
  output logic              start_ok_o,
  output logic [ADDR_W-1:0] replay_addr_o,
  output logic              replay_we_o,
  output logic [STRB_W-1:0] replay_strb_o
);
  localparam int SIG_N = 2;

  logic [SIG_N-1:0] raw_in, sync_in;
  logic             berr_s, halt_s, capture;

  assign raw_in = {halt_i, bus_err_i};
  assign berr_s = sync_in[0];
  assign halt_s = sync_in[1];

  buserr_sync #(.WIDTH(SIG_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(raw_in),
    .sync_o (sync_in)
  );

  buserr_retry_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cyc_active_i (cyc_active_i),
    .berr_s_i     (berr_s),
    .halt_s_i     (halt_s),
    .capture_o    (capture),
    .exc_req_o    (exc_req_o),
    .rerun_req_o  (rerun_req_o),
    .bus_float_o  (bus_float_o),
    .strobe_term_o(strobe_term_o),
    .start_ok_o   (start_ok_o)
  );

  buserr_attr_hold #(.ADDR_W(ADDR_W), .STRB_W(STRB_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .addr_i   (cyc_addr_i),
    .we_i     (cyc_we_i),
    .strb_i   (cyc_strb_i),
    .addr_o   (replay_addr_o),
    .we_o     (replay_we_o),
    .strb_o   (replay_strb_o)
  );
endmodule

// File: rtl/buserr_retry_chk.sv
module buserr_retry_chk #(
  parameter int ADDR_W = 24,
  parameter int STRB_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cyc_active_i,
  input logic              exc_req_o,
  input logic              rerun_req_o,
  input logic              bus_float_o,
  input logic              strobe_term_o,
  input logic              start_ok_o,
  input logic [ADDR_W-1:0] replay_addr_o,
  input logic              replay_we_o,
  input logic [STRB_W-1:0] replay_strb_o
);
  AST_EXC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |=> !exc_req_o); // R3

  AST_TRAP_NOT_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> !bus_float_o); // R4

  AST_RERUN_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rerun_req_o |=> !rerun_req_o); // R5

  AST_RERUN_AFTER_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rerun_req_o |-> $past(bus_float_o)); // R5

  AST_FLOAT_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_float_o |-> strobe_term_o); // R4

  AST_FAULT_NEEDS_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_term_o) |-> $past(cyc_active_i)); // R2

  AST_REPLAY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_float_o && $past(bus_float_o)) |->
      ($stable(replay_addr_o) && $stable(replay_we_o) && $stable(replay_strb_o))); // R7

  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ok_o |-> !strobe_term_o); // R8
endmodule

bind buserr_retry_ctrl buserr_retry_chk #(.ADDR_W(ADDR_W), .STRB_W(STRB_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cyc_active_i (cyc_active_i),
  .exc_req_o    (exc_req_o),
  .rerun_req_o  (rerun_req_o),
  .bus_float_o  (bus_float_o),
  .strobe_term_o(strobe_term_o),
  .start_ok_o   (start_ok_o),
  .replay_addr_o(replay_addr_o),
  .replay_we_o  (replay_we_o),
  .replay_strb_o(replay_strb_o)
);

// File: tb/buserr_retry_ctrl_test.sv
`timescale 1ns/1ps
module buserr_retry_ctrl_test;
  localparam int ADDR_W = 24;
  localparam int STRB_W = 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cyc_active_i = 1'b0;
  logic [ADDR_W-1:0] cyc_addr_i = '0;
  logic              cyc_we_i = 1'b0;
  logic [STRB_W-1:0] cyc_strb_i = '0;
  logic              bus_err_i = 1'b0;
  logic              halt_i = 1'b0;
  logic              exc_req_o, rerun_req_o, bus_float_o, strobe_term_o, start_ok_o;
  logic [ADDR_W-1:0] replay_addr_o;
  logic              replay_we_o;
  logic [STRB_W-1:0] replay_strb_o;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  buserr_retry_ctrl #(.ADDR_W(ADDR_W), .STRB_W(STRB_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_active_i(cyc_active_i),
    .cyc_addr_i(cyc_addr_i), .cyc_we_i(cyc_we_i), .cyc_strb_i(cyc_strb_i),
    .bus_err_i(bus_err_i), .halt_i(halt_i),
    .exc_req_o(exc_req_o), .rerun_req_o(rerun_req_o), .bus_float_o(bus_float_o),
    .strobe_term_o(strobe_term_o), .start_ok_o(start_ok_o),
    .replay_addr_o(replay_addr_o), .replay_we_o(replay_we_o), .replay_strb_o(replay_strb_o)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // halt onset offset hoff relative to error onset (t=3); hoff<=0 parks, hoff>0 traps
  task automatic run_case(input logic [ADDR_W-1:0] a, input logic w, input logic [STRB_W-1:0] s, input int hoff);
    bit park;
    string rq;
    park = (hoff <= 0);
    rq = park ? "R4" : "R6";
    cyc_active_i = 1'b0; bus_err_i = 1'b0; halt_i = 1'b0;
    repeat (5) tick();
    cyc_active_i = 1'b1; cyc_addr_i = a; cyc_we_i = w; cyc_strb_i = s;
    for (int t = 0; t <= 16; t++) begin
      bus_err_i = (t >= 3) && (t < 8);
      halt_i    = (t >= 3 + hoff) && (t < 12);
      if (t == 6) begin
        cyc_addr_i = ~a; cyc_we_i = ~w; cyc_strb_i = ~s;
      end
      tick();
      case (t)
        4: chk("R3", "no early response", {exc_req_o, bus_float_o, strobe_term_o}, 3'b000);
        5: begin
          chk(rq, "float at fault edge", bus_float_o, park);
          chk(park ? "R4" : "R3", "exc at fault edge", exc_req_o, !park);
          chk("R3", "term at fault edge", strobe_term_o, 1'b1);
          chk("R7", "replay addr", replay_addr_o, a);
          chk("R7", "replay attrs", {replay_we_o, replay_strb_o}, {w, s});
        end
        6: chk("R3", "exc pulse ended", exc_req_o, 1'b0);
        8: begin
          chk("R8", "held error no second exc", exc_req_o, 1'b0);
          chk("R8", "start blocked", start_ok_o, 1'b0);
        end
        10: begin
          chk("R7", "replay held", {replay_addr_o, replay_we_o, replay_strb_o}, {a, w, s});
          chk("R8", "term after error release", strobe_term_o, park);
          chk("R8", "start after error release", start_ok_o, !park);
          chk("R5", "float held while halt", bus_float_o, park);
        end
        13: chk("R5", "float before halt sync", bus_float_o, park);
        14: begin
          chk(rq == "R6" ? "R6" : "R5", "rerun at halt release", rerun_req_o, park);
          chk("R5", "float dropped", bus_float_o, 1'b0);
        end
        15: begin
          chk("R5", "rerun pulse ended", rerun_req_o, 1'b0);
          chk("R8", "term clear", strobe_term_o, 1'b0);
          chk("R8", "start ok", start_ok_o, 1'b1);
        end
        default: ;
      endcase
    end
    cyc_active_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1", "reset outputs", {exc_req_o, rerun_req_o, bus_float_o, strobe_term_o, start_ok_o}, 5'b00001);
    rst_ni = 1'b1;
    tick();
    chk("R1", "replay after reset", {replay_addr_o, replay_we_o, replay_strb_o}, '0);

    // R2: error and halt with no active cycle
    cyc_addr_i = 24'h123456;
    bus_err_i = 1'b1; halt_i = 1'b1;
    for (int t = 0; t < 8; t++) begin
      tick();
      chk("R2", "idle error ignored", {exc_req_o, bus_float_o, strobe_term_o, rerun_req_o}, 4'b0000);
    end
    bus_err_i = 1'b0; halt_i = 1'b0;
    repeat (4) tick();
    chk("R2", "replay untouched", replay_addr_o, 24'h0);

    for (int i = 0; i < 4; i++) begin
      for (int h = -2; h <= 2; h++) begin
        run_case(ADDR_W'(32'h13579B * (i + 1)), i[0], STRB_W'(i + 1), h);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule